// File: doc/BRIEF.md
# Vector Element Widening Repacker

This unit moves a run of narrow 16-bit elements out of a stream of 64-bit source words into 32-bit slots of consecutive 64-bit destination registers. Each element is zero-extended on the way. A start pulse supplies the element count and the first destination register index. Source words then arrive through a valid/ready handshake. The unit emits one register write per cycle. Each write carries an index, 64 data bits and a byte-enable mask. When the element count is odd, the upper half of the final register is left untouched.

Each source word holds four elements and each destination register holds two. Every accepted word therefore turns into at most two register writes. The unit holds its input ready low while it emits those writes. After the last write it raises a single-cycle done pulse. A count of zero makes no writes and finishes at once.

Top module: `elem_widen_pack`

## Requirements
- R1: In every register write, bits 31:16 and 63:48 are zero, so each 32-bit slot holds a zero-extended 16-bit element.
- R2: Element k of a source word is taken from bits 16k+15:16k of that word (bytes 2k and 2k+1, little-endian). Source word w supplies elements 4w to 4w+3 of the vector.
- R3: Write i places element 2i in bits 31:0 and element 2i+1 in bits 63:32.
- R4: Write i targets register index (base + i) modulo 2^IDX_W.
- R5: A write holding two elements uses mask 0xFF. The last write of an odd-length vector uses mask 0x0F and carries zero in bits 63:32.
- R6: A vector of length L (0 to 64) produces exactly ceil(L/2) writes and consumes exactly ceil(L/4) source words.
- R7: Input ready is high only while the unit waits for a source word it still needs. It is low during reset, while idle and once the last needed word has been taken.
- R8: Done is a one-cycle pulse in the cycle after the last write. For L = 0 it appears in the cycle after start, with no write.
- R9: A start pulse that arrives while an operation is in progress is ignored and does not change that operation's writes.
- R10: During and right after reset, write enable, done and input ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| vlIn | input | VL_W (7) | Number of elements to move, 0 to MAX_VL |
| baseIdx | input | IDX_W (6) | First destination register index |
| srcValid | input | 1 | Source word offered |
| srcReady | output | 1 | Unit accepts a source word this cycle |
| srcData | input | 64 | Source word holding four 16-bit elements |
| wrEn | output | 1 | Register write strobe |
| wrIdx | output | IDX_W (6) | Destination register index |
| wrData | output | 64 | Two zero-extended 32-bit elements |
| wrMask | output | 8 | Byte enables for the write |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that the element count given with an accepted start never exceeds MAX_VL. A guard property flags any stimulus that breaks this. The bench draws lengths only from 0 to 64, over random base indices that include wrap-around past the top register. It inserts random gaps in srcValid and keeps srcValid high with junk data after the last needed word, so that a ready that stays high too long would be caught. A second start is also pulsed in the middle of some longer operations.

// File: rtl/ewp_pkg.sv
package ewp_pkg;
  parameter int WORD_W = 64;
  parameter int SRC_W  = 16;
  parameter int DST_W  = 32;
  localparam int SRC_PER_WORD  = WORD_W / SRC_W;
  localparam int DST_PER_REG   = WORD_W / DST_W;
  localparam int REGS_PER_WORD = SRC_PER_WORD / DST_PER_REG;
  localparam int SEL_W   = (REGS_PER_WORD > 1) ? $clog2(REGS_PER_WORD) : 1;
  localparam int LANE_CW = $clog2(DST_PER_REG + 1);
  localparam int BYTE_CNT   = WORD_W / 8;
  localparam int LANE_BYTES = DST_W / 8;

  typedef struct packed {
    logic               loadBase;
    logic               loadWord;
    logic               emit;
    logic [SEL_W-1:0]   regSel;
    logic [LANE_CW-1:0] lanesValid;
  } ewpStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EMIT, ST_FIN} ewpState_t;
endpackage

// File: rtl/ewp_ctrl.sv
module ewp_ctrl
  import ewp_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [VL_W-1:0] vlIn,
  input  logic            srcValid,
  output logic            srcReady,
  output logic            wrEn,
  output logic            done,
  output ewpStrobe_t      strb
);
  ewpState_t          state;
  logic [VL_W-1:0]    elemLeft;
  logic [VL_W-1:0]    nextLeft;
  logic [SEL_W-1:0]   regSel;
  logic [LANE_CW-1:0] lanes;

  always_comb begin
    if (elemLeft >= VL_W'(DST_PER_REG)) lanes = LANE_CW'(DST_PER_REG);
    else                                 lanes = LANE_CW'(elemLeft);
    nextLeft = elemLeft - VL_W'(lanes);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      elemLeft <= '0;
      regSel   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          elemLeft <= vlIn;
          regSel   <= '0;
          state    <= (vlIn == '0) ? ST_FIN : ST_FETCH;
        end
        ST_FETCH: if (srcValid) begin
          regSel <= '0;
          state  <= ST_EMIT;
        end
        ST_EMIT: begin
          elemLeft <= nextLeft;
          if (nextLeft == '0) begin
            state <= ST_FIN;
          end else if (regSel == SEL_W'(REGS_PER_WORD - 1)) begin
            regSel <= '0;
            state  <= ST_FETCH;
          end else begin
            regSel <= regSel + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign srcReady        = (state == ST_FETCH);
  assign wrEn            = (state == ST_EMIT);
  assign done            = (state == ST_FIN);
  assign strb.loadBase   = (state == ST_IDLE) && start;
  assign strb.loadWord   = (state == ST_FETCH) && srcValid;
  assign strb.emit       = (state == ST_EMIT);
  assign strb.regSel     = regSel;
  assign strb.lanesValid = lanes;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R7
  ready_need_chk: assert property (@(posedge clk) disable iff (rst) srcReady |-> elemLeft != '0);
  // R6
  vl_range_chk: assert property (@(posedge clk) disable iff (rst)
    (start && state == ST_IDLE) |-> (int'(vlIn) <= MAX_VL));
  // R8
  fin_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && nextLeft == '0) |=> done);
endmodule

// File: rtl/ewp_dpath.sv
module ewp_dpath
  import ewp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  ewpStrobe_t          strb,
  input  logic [IDX_W-1:0]    baseIdx,
  input  logic [WORD_W-1:0]   srcData,
  output logic [IDX_W-1:0]    wrIdx,
  output logic [WORD_W-1:0]   wrData,
  output logic [BYTE_CNT-1:0] wrMask
);
  logic [WORD_W-1:0] wordQ;
  logic [IDX_W-1:0]  idxQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      wordQ <= '0;
      idxQ  <= '0;
    end else begin
      if (strb.loadBase)  idxQ <= baseIdx;
      else if (strb.emit) idxQ <= idxQ + 1'b1;
      if (strb.loadWord)  wordQ <= srcData;
    end
  end

  assign wrIdx = idxQ;

  for (genvar j = 0; j < DST_PER_REG; j++) begin : g_lane
    logic [SRC_W-1:0] srcElem;
    logic             laneOn;
    assign srcElem = SRC_W'(wordQ >> ((32'(strb.regSel) * DST_PER_REG + j) * SRC_W));
    assign laneOn  = (LANE_CW'(j) < strb.lanesValid);
    assign wrData[j*DST_W +: DST_W] = laneOn ? {{(DST_W-SRC_W){1'b0}}, srcElem} : '0;
    assign wrMask[j*LANE_BYTES +: LANE_BYTES] = {LANE_BYTES{laneOn}};

    // R1
    zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
      strb.emit |-> wrData[j*DST_W+SRC_W +: DST_W-SRC_W] == '0);
  end

  // R5
  partial_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.emit && wrMask != '1) |-> (wrMask == BYTE_CNT'(8'h0F) && wrData[WORD_W-1:DST_W] == '0));
  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.emit && $past(strb.emit)) |-> wrIdx == IDX_W'($past(wrIdx) + 1'b1));
endmodule

// File: rtl/elem_widen_pack.sv
module elem_widen_pack
  import ewp_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = 6,
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [VL_W-1:0]     vlIn,
  input  logic [IDX_W-1:0]    baseIdx,
  input  logic                srcValid,
  output logic                srcReady,
  input  logic [WORD_W-1:0]   srcData,
  output logic                wrEn,
  output logic [IDX_W-1:0]    wrIdx,
  output logic [WORD_W-1:0]   wrData,
  output logic [BYTE_CNT-1:0] wrMask,
  output logic                done
);
  ewpStrobe_t strb;

  ewp_ctrl #(.MAX_VL(MAX_VL), .VL_W(VL_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .vlIn(vlIn),
    .srcValid(srcValid), .srcReady(srcReady),
    .wrEn(wrEn), .done(done), .strb(strb)
  );

  ewp_dpath #(.IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .baseIdx(baseIdx), .srcData(srcData),
    .wrIdx(wrIdx), .wrData(wrData), .wrMask(wrMask)
  );
endmodule

// File: tb/tb_elem_widen_pack.sv
module tb_elem_widen_pack;
  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0;
  logic [6:0]  vlIn = 0;
  logic [5:0]  baseIdx = 0;
  logic        srcValid = 0;
  logic        srcReady;
  logic [63:0] srcData = 0;
  logic        wrEn;
  logic [5:0]  wrIdx;
  logic [63:0] wrData;
  logic [7:0]  wrMask;
  logic        done;

  elem_widen_pack dut (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [63:0] srcWords [0:15];
  logic [5:0]  recIdx  [0:63];
  logic [63:0] recData [0:63];
  logic [7:0]  recMask [0:63];
  int          recCyc  [0:63];
  int          nW = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) if (!rst && wrEn) begin
    if (nW < 64) begin
      recIdx[nW] = wrIdx; recData[nW] = wrData; recMask[nW] = wrMask; recCyc[nW] = cyc;
    end
    nW++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] elemOf(input int k);
    return 16'((srcWords[k >> 2] >> ((k & 3) * 16)) & 64'hFFFF);
  endfunction

  task automatic runOp(input int vl, input int base, input int gapPct, input bit busyStart);
    int nWords, fed, guard, lanes, doneCyc;
    logic [63:0] expData;
    bit accept;
    nWords = (vl + 3) / 4;
    for (int w = 0; w < 16; w++) srcWords[w] = {$urandom, $urandom};
    @(negedge clk);
    nW = 0;
    start = 1; vlIn = 7'(vl); baseIdx = 6'(base);
    @(negedge clk);
    start = 0;
    if (vl == 0) begin
      chk(done == 1'b1, "R8 done after empty start", 64'(done), 64'd1);
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", 64'(done), 64'd0);
      chk(nW == 0, "R6 no writes for zero length", 64'(nW), 64'd0);
      return;
    end
    fed = 0; guard = 0;
    while (fed < nWords && guard < 5000) begin
      srcValid = ($urandom_range(0, 99) >= gapPct);
      srcData  = srcWords[fed];
      if (busyStart && fed == 1) begin start = 1; vlIn = 7'd3; baseIdx = 6'(base + 20); end
      accept = srcValid && srcReady;
      @(negedge clk);
      start = 0;
      if (accept) fed++;
      guard++;
    end
    srcValid = 1; srcData = 64'hDEAD_BEEF_CAFE_F00D;
    guard = 0;
    while (!done && guard < 200) begin
      // R7: no further words requested once all are taken
      chk(srcReady == 1'b0, "R7 ready low after last word", 64'(srcReady), 64'd0);
      @(negedge clk);
      guard++;
    end
    doneCyc = cyc;
    chk(done == 1'b1, "R8 done reached", 64'(done), 64'd1);
    chk(fed == nWords, "R6 words consumed", 64'(fed), 64'(nWords));
    chk(nW == (vl + 1) / 2, "R6 write count", 64'(nW), 64'((vl + 1) / 2));
    if (nW > 0 && nW <= 64)
      chk(doneCyc == recCyc[nW-1] + 1, "R8 done follows last write", 64'(doneCyc), 64'(recCyc[nW-1] + 1));
    @(negedge clk);
    srcValid = 0;
    chk(done == 1'b0, "R8 done single pulse", 64'(done), 64'd0);
    chk(srcReady == 1'b0, "R7 ready low when idle", 64'(srcReady), 64'd0);
    for (int i = 0; i < nW && i < 32; i++) begin
      lanes = (vl - 2 * i >= 2) ? 2 : vl - 2 * i;
      expData = 64'(elemOf(2 * i));
      if (lanes == 2) expData[47:32] = elemOf(2 * i + 1);
      chk(recIdx[i] == 6'(base + i), "R4 index", 64'(recIdx[i]), 64'(6'(base + i)));
      chk((recData[i] & 64'hFFFF_0000_FFFF_0000) == 0, "R1 zero extension", recData[i], 64'd0);
      chk(recData[i][15:0] == elemOf(2 * i), "R2 element source bytes", 64'(recData[i][15:0]), 64'(elemOf(2 * i)));
      chk(recData[i] == expData, "R3 packing", recData[i], expData);
      chk(recMask[i] == ((lanes == 2) ? 8'hFF : 8'h0F), "R5 byte mask", 64'(recMask[i]),
          64'((lanes == 2) ? 8'hFF : 8'h0F));
      if (busyStart)
        chk(recIdx[i] == 6'(base + i), "R9 late start ignored", 64'(recIdx[i]), 64'(6'(base + i)));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) begin
      @(negedge clk);
      chk(!wrEn && !done && !srcReady, "R10 reset outputs", {61'd0, wrEn, done, srcReady}, 64'd0);
    end
    rst = 0;
    @(negedge clk);
    chk(!wrEn && !done && !srcReady, "R10 outputs after reset", {61'd0, wrEn, done, srcReady}, 64'd0);
    runOp(7, 8, 0, 0);
    runOp(0, 3, 0, 0);
    runOp(1, 0, 0, 0);
    runOp(2, 5, 30, 0);
    runOp(4, 10, 0, 0);
    runOp(5, 11, 50, 0);
    runOp(64, 0, 20, 0);
    runOp(8, 62, 0, 0);
    runOp(13, 40, 10, 1);
    runOp(0, 1, 0, 0);
    for (int n = 0; n < 40; n++)
      runOp($urandom_range(0, 64), $urandom_range(0, 63), $urandom_range(0, 60), n[2]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule